// File: doc/BRIEF.md
# Two-wire slave protocol front end

This block is the bus-facing half of a register slave on a two-wire serial bus. SCL and SDA are synchronised into a fast system clock. Start and stop conditions are detected from the registered line levels, and bytes are shifted in and out on SCL edges. SDA is driven only through an open-drain enable: a high `sda_oe_o` pulls the line low. The address byte is compared with a fixed 4-bit device type and four strap pins. The second byte is split into a 4-bit opcode, a 2-bit register pointer and a 2-bit unit pointer, and is passed to a command engine. One optional data byte follows, carrying a 6-bit value.

The command engine sits beside this block. It holds `busy_i` high while a nonvolatile store runs. During that time the front end refuses its own address, so a master finds out when the store has finished by repeating start plus address until it gets an acknowledge. For the two read opcodes, the block shifts `tx_val_i` out as a byte whose upper two bits are zero. `store_go_o` marks the stop condition that closes a store command, which is the moment the engine begins its write cycle.

Top module: `twowire_slave_fe`

## Requirements
- R1: After reset `sda_oe_o` is low and none of `cmd_valid_o`, `wr_valid_o` or `store_go_o` has pulsed.
- R2: The address byte is acknowledged only when its upper four bits equal `DEV_TYPE` (default 0101) and its lower four bits equal `strap_i`. After a refused address, later bytes of that transfer get no acknowledge and produce no command.
- R3: While `busy_i` is high a matching address is not acknowledged. Once `busy_i` is low it is acknowledged again.
- R4: The byte after an acknowledged address is acknowledged and gives a one-cycle `cmd_valid_o`, with opcode = bits 7:4, register pointer = bits 3:2 and unit pointer = bits 1:0.
- R5: After a non-read instruction, one further byte is acknowledged and gives a one-cycle `wr_valid_o`, with `wr_data_o` = its low six bits.
- R6: A second byte after the data byte is not acknowledged and produces no `wr_valid_o`.
- R7: For opcodes 1001 and 1011 the slave sends `{2'b00, tx_val_i}` MSB first after the instruction acknowledge, driving SDA only during SCL low, and releases SDA after the eighth bit.
- R8: If the master acknowledges a read byte, the byte is sent again. If the master does not acknowledge, the slave returns to idle and drives nothing until the next start.
- R9: `store_go_o` pulses for one cycle at the stop that ends a transfer whose instruction was 1110 or 1000, or 1100 followed by an acknowledged data byte. No other transfer produces the pulse.
- R10: A start at any point abandons the current transfer, including a partly received byte and any pending store, and restarts address reception.
- R11: `sda_oe_o` changes only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_oe_o | output | 1 | High pulls SDA low |
| strap_i | input | STRAP_W | Low address bits from strap pins |
| busy_i | input | 1 | Nonvolatile store in progress |
| tx_val_i | input | VAL_W | Value returned by read opcodes |
| cmd_valid_o | output | 1 | Instruction byte received |
| cmd_op_o | output | 4 | Opcode field |
| cmd_reg_o | output | 2 | Register pointer field |
| cmd_pot_o | output | 2 | Unit pointer field |
| wr_valid_o | output | 1 | Data byte received |
| wr_data_o | output | VAL_W | Low bits of the data byte |
| store_go_o | output | 1 | Stop closed a store command |

## Verification
Address matching is driven from a vector table. The table mixes matching and mismatching strap bits, a wrong device type and an asserted busy flag, which separates the strap compare, the type compare and polling refusal. Directed transfers cover each instruction class: a write with data, reads of both opcodes with master ACK and NACK, the three store forms, and a store without its data byte. They also cut a transfer short with a repeated start in the middle of a byte, so that store arming, resend on ACK and abort paths each give a visibly different acknowledge or pulse count.

// File: rtl/twfe_pkg.sv
package twfe_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK} fe_state_e;
  typedef enum logic [1:0] {BK_ADDR, BK_INSTR, BK_DATA, BK_EXTRA} byte_kind_e;

  localparam logic [3:0] OP_RD_WIPER  = 4'b1001;
  localparam logic [3:0] OP_RD_REG    = 4'b1011;
  localparam logic [3:0] OP_WR_REG    = 4'b1100;
  localparam logic [3:0] OP_STORE_ONE = 4'b1110;
  localparam logic [3:0] OP_STORE_ALL = 4'b1000;

  typedef struct packed {
    logic [3:0] op;
    logic [1:0] sel_reg;
    logic [1:0] sel_pot;
  } instr_t;
endpackage

// File: rtl/twfe_sync.sv
module twfe_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] line_i,
  output logic [LINES-1:0] sync_o,
  output logic [LINES-1:0] prev_o
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    logic              prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        chain  <= '1;   // bus idles high
        prev_q <= 1'b1;
      end else begin
        chain  <= {chain[STAGES-2:0], line_i[g]};
        prev_q <= chain[STAGES-1];
      end
    end
    assign sync_o[g] = chain[STAGES-1];
    assign prev_o[g] = prev_q;
  end
endmodule

// File: rtl/twfe_decode.sv
module twfe_decode
  import twfe_pkg::*;
(
  input  logic [7:0] byte_i,
  output instr_t     fields_o,
  output logic       is_read_o,
  output logic       store_now_o,
  output logic       store_data_o
);
  assign fields_o = instr_t'(byte_i);

  always_comb begin
    is_read_o    = (fields_o.op == OP_RD_WIPER) || (fields_o.op == OP_RD_REG);
    store_now_o  = (fields_o.op == OP_STORE_ONE) || (fields_o.op == OP_STORE_ALL);
    store_data_o = (fields_o.op == OP_WR_REG);
  end
endmodule

// File: rtl/twowire_slave_fe.sv
module twowire_slave_fe
  import twfe_pkg::*;
#(
  parameter int              TYPE_W      = 4,
  parameter logic [TYPE_W-1:0] DEV_TYPE  = 4'b0101,
  parameter int              VAL_W       = 6,
  parameter int              SYNC_STAGES = 2,
  localparam int             BYTE_W      = 8,
  localparam int             STRAP_W     = BYTE_W - TYPE_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               busy_i,
  input  logic [VAL_W-1:0]   tx_val_i,
  output logic               cmd_valid_o,
  output logic [3:0]         cmd_op_o,
  output logic [1:0]         cmd_reg_o,
  output logic [1:0]         cmd_pot_o,
  output logic               wr_valid_o,
  output logic [VAL_W-1:0]   wr_data_o,
  output logic               store_go_o
);
  localparam int CNT_W = $clog2(BYTE_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

  logic [1:0] syn, prv;
  logic scl_s, sda_s, scl_q, sda_q;
  logic scl_rise, scl_fall, start_det, stop_det;

  twfe_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .line_i({scl_i, sda_i}),
    .sync_o(syn),
    .prev_o(prv)
  );

  assign scl_s = syn[1];
  assign sda_s = syn[0];
  assign scl_q = prv[1];
  assign sda_q = prv[0];

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

  fe_state_e        state_q;
  byte_kind_e       kind_q;
  logic [CNT_W-1:0] cnt_q;
  logic [BYTE_W-1:0] shreg_q;
  logic             oe_q;
  logic             is_read_q, store_arm_q, store_on_data_q, mack_ok_q;
  logic             cmd_valid_q, wr_valid_q, store_go_q;
  instr_t           instr_q;
  logic [VAL_W-1:0] wr_data_q;

  instr_t dec_fields;
  logic   dec_read, dec_store_now, dec_store_data;

  twfe_decode u_decode (
    .byte_i      (shreg_q),
    .fields_o    (dec_fields),
    .is_read_o   (dec_read),
    .store_now_o (dec_store_now),
    .store_data_o(dec_store_data)
  );

  logic addr_match;
  assign addr_match = (shreg_q == {DEV_TYPE, strap_i});

  logic [BYTE_W-1:0] tx_word;
  assign tx_word = {{(BYTE_W-VAL_W){1'b0}}, tx_val_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q         <= ST_IDLE;
      kind_q          <= BK_ADDR;
      cnt_q           <= '0;
      shreg_q         <= '0;
      oe_q            <= 1'b0;
      is_read_q       <= 1'b0;
      store_arm_q     <= 1'b0;
      store_on_data_q <= 1'b0;
      mack_ok_q       <= 1'b0;
      cmd_valid_q     <= 1'b0;
      wr_valid_q      <= 1'b0;
      store_go_q      <= 1'b0;
      instr_q         <= '0;
      wr_data_q       <= '0;
    end else begin
      cmd_valid_q <= 1'b0;
      wr_valid_q  <= 1'b0;
      store_go_q  <= 1'b0;
      if (start_det) begin
        state_q         <= ST_RX;
        kind_q          <= BK_ADDR;
        cnt_q           <= '0;
        oe_q            <= 1'b0;
        store_arm_q     <= 1'b0;
        store_on_data_q <= 1'b0;
        mack_ok_q       <= 1'b0;
      end else if (stop_det) begin
        state_q     <= ST_IDLE;
        oe_q        <= 1'b0;
        store_go_q  <= store_arm_q;
        store_arm_q <= 1'b0;
      end else begin
        unique case (state_q)
          ST_RX: begin
            if (scl_rise && cnt_q != CNT_FULL) begin
              shreg_q <= {shreg_q[BYTE_W-2:0], sda_s};
              cnt_q   <= cnt_q + 1'b1;
            end else if (scl_fall && cnt_q == CNT_FULL) begin
              unique case (kind_q)
                BK_ADDR: begin
                  if (addr_match && !busy_i) begin
                    oe_q    <= 1'b1;
                    state_q <= ST_ACK;
                  end else begin
                    state_q <= ST_IDLE;
                  end
                end
                BK_INSTR: begin
                  oe_q            <= 1'b1;
                  state_q         <= ST_ACK;
                  instr_q         <= dec_fields;
                  cmd_valid_q     <= 1'b1;
                  is_read_q       <= dec_read;
                  store_arm_q     <= dec_store_now;
                  store_on_data_q <= dec_store_data;
                end
                BK_DATA: begin
                  oe_q       <= 1'b1;
                  state_q    <= ST_ACK;
                  wr_data_q  <= shreg_q[VAL_W-1:0];
                  wr_valid_q <= 1'b1;
                  if (store_on_data_q) store_arm_q <= 1'b1;
                end
                default: state_q <= ST_IDLE;
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              cnt_q <= '0;
              unique case (kind_q)
                BK_ADDR: begin
                  oe_q    <= 1'b0;
                  kind_q  <= BK_INSTR;
                  state_q <= ST_RX;
                end
                BK_INSTR: begin
                  if (is_read_q) begin
                    state_q <= ST_TX;
                    shreg_q <= tx_word;
                    oe_q    <= ~tx_word[BYTE_W-1];
                  end else begin
                    oe_q    <= 1'b0;
                    kind_q  <= BK_DATA;
                    state_q <= ST_RX;
                  end
                end
                BK_DATA: begin
                  oe_q    <= 1'b0;
                  kind_q  <= BK_EXTRA;
                  state_q <= ST_RX;
                end
                default: begin
                  oe_q    <= 1'b0;
                  state_q <= ST_IDLE;
                end
              endcase
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall) begin
              if (cnt_q == CNT_FULL) begin
                oe_q      <= 1'b0;
                state_q   <= ST_MACK;
                cnt_q     <= '0;
                mack_ok_q <= 1'b0;
              end else begin
                shreg_q <= {shreg_q[BYTE_W-2:0], 1'b0};
                oe_q    <= ~shreg_q[BYTE_W-2];
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              mack_ok_q <= ~sda_s;
            end else if (scl_fall) begin
              if (mack_ok_q) begin
                state_q <= ST_TX;
                shreg_q <= tx_word;
                oe_q    <= ~tx_word[BYTE_W-1];
                cnt_q   <= '0;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o    = oe_q;
  assign cmd_valid_o = cmd_valid_q;
  assign cmd_op_o    = instr_q.op;
  assign cmd_reg_o   = instr_q.sel_reg;
  assign cmd_pot_o   = instr_q.sel_pot;
  assign wr_valid_o  = wr_valid_q;
  assign wr_data_o   = wr_data_q;
  assign store_go_o  = store_go_q;
endmodule

// File: rtl/twfe_chk.sv
module twfe_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_s,
  input logic sda_oe_o,
  input logic cmd_valid_o,
  input logic wr_valid_o,
  input logic store_go_o
);
  // R11
  oe_low_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_o != $past(sda_oe_o)) |-> !$past(scl_s));

  // R4
  cmd_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !cmd_valid_o);

  // R5
  wr_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |=> !wr_valid_o);

  // R9
  store_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_go_o |=> !store_go_o);

  // R9
  event_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cmd_valid_o, wr_valid_o, store_go_o}));
endmodule

bind twowire_slave_fe twfe_chk u_twfe_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .scl_s      (scl_s),
  .sda_oe_o   (sda_oe_o),
  .cmd_valid_o(cmd_valid_o),
  .wr_valid_o (wr_valid_o),
  .store_go_o (store_go_o)
);

// File: tb/twowire_slave_fe_bench.sv
module twowire_slave_fe_bench;
  localparam int Q = 10;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic [3:0] strap = 4'h3;
  logic       busy = 1'b0;
  logic [5:0] tx_val = 6'h00;
  logic       sda_oe, cmd_valid, wr_valid, store_go;
  logic [3:0] cmd_op;
  logic [1:0] cmd_reg, cmd_pot;
  logic [5:0] wr_data;
  logic       sda_bus;
  assign sda_bus = sda_m & ~sda_oe;

  twowire_slave_fe u_twowire_slave_fe (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .strap_i(strap), .busy_i(busy), .tx_val_i(tx_val),
    .cmd_valid_o(cmd_valid), .cmd_op_o(cmd_op), .cmd_reg_o(cmd_reg),
    .cmd_pot_o(cmd_pot), .wr_valid_o(wr_valid), .wr_data_o(wr_data),
    .store_go_o(store_go)
  );

  int n_chk = 0, n_fail = 0;
  int n_cmd = 0, n_wr = 0, n_store = 0, n_viol = 0;
  logic [7:0] last_cmd = 8'h00;
  logic [5:0] last_wr = 6'h00;
  logic scl_d = 1'b1, oe_d = 1'b0;

  always @(posedge clk) begin
    if (cmd_valid) begin n_cmd++; last_cmd = {cmd_op, cmd_reg, cmd_pot}; end
    if (wr_valid) begin n_wr++; last_wr = wr_data; end
    if (store_go) n_store++;
    if (scl_m && scl_d && sda_oe != oe_d) n_viol++;
    scl_d = scl_m;
    oe_d  = sda_oe;
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_io(input logic b, output logic seen);
    sda_m = b; wq(Q);
    scl_m = 1'b1; wq(Q);
    seen = sda_bus; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b1; wq(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_io(b[i], s);
    bit_io(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic mack);
    logic s;
    for (int i = 7; i >= 0; i--) begin bit_io(1'b1, s); b[i] = s; end
    bit_io(~mack, s);
  endtask

  // {strap, address byte, busy, expected ack}
  localparam logic [13:0] VEC [0:5] = '{
    {4'h3, 8'h53, 1'b0, 1'b1},
    {4'h3, 8'h52, 1'b0, 1'b0},
    {4'hA, 8'h5A, 1'b0, 1'b1},
    {4'hA, 8'h7A, 1'b0, 1'b0},
    {4'h3, 8'h53, 1'b1, 1'b0},
    {4'h0, 8'h50, 1'b0, 1'b1}
  };

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] rb;
    int c0, w0, s0;
    wq(5);
    check("R1 oe in reset", sda_oe, 0);
    rst_n = 1'b1; wq(5);
    check("R1 oe after reset", sda_oe, 0);
    check("R1 no events", n_cmd + n_wr + n_store, 0);

    // address table: R2 strap/type compare, R3 busy refusal
    for (int v = 0; v < 6; v++) begin
      strap = VEC[v][13:10];
      busy  = VEC[v][1];
      wq(2);
      bus_start();
      send_byte(VEC[v][9:2], ack);
      check(VEC[v][1] ? "R3 busy addr ack" : "R2 addr ack", ack, VEC[v][0]);
      if (!VEC[v][0]) begin
        c0 = n_cmd;
        send_byte(8'hA0, ack);
        check("R2 ignored instr ack", ack, 0);
        check("R2 ignored instr cmd", n_cmd, c0);
      end
      bus_stop();
    end
    busy = 1'b0; strap = 4'h3;

    // R4/R5/R6 write with data then extra byte
    c0 = n_cmd; w0 = n_wr; s0 = n_store;
    bus_start();
    send_byte(8'h53, ack);
    send_byte(8'hA6, ack);
    check("R4 instr ack", ack, 1);
    check("R4 cmd count", n_cmd, c0 + 1);
    check("R4 cmd fields", last_cmd, 8'hA6);
    send_byte(8'h2B, ack);
    check("R5 data ack", ack, 1);
    check("R5 wr count", n_wr, w0 + 1);
    check("R5 wr data", last_wr, 6'h2B);
    send_byte(8'h15, ack);
    check("R6 extra nack", ack, 0);
    check("R6 extra no wr", n_wr, w0 + 1);
    bus_stop();
    check("R9 no store on plain write", n_store, s0);

    // R7/R8 read with ACK, then NACK, then idle
    tx_val = 6'h2D;
    bus_start();
    send_byte(8'h53, ack);
    send_byte(8'h93, ack);
    check("R7 read instr ack", ack, 1);
    recv_byte(rb, 1'b1);
    check("R7 read byte", rb, 8'h2D);
    recv_byte(rb, 1'b0);
    check("R8 resend after ack", rb, 8'h2D);
    recv_byte(rb, 1'b0);
    check("R8 idle after nack", rb, 8'hFF);
    bus_stop();

    tx_val = 6'h3F;
    bus_start();
    send_byte(8'h53, ack);
    send_byte(8'hB4, ack);
    check("R4 read reg fields", last_cmd, 8'hB4);
    recv_byte(rb, 1'b0);
    check("R7 second read opcode", rb, 8'h3F);
    bus_stop();

    // R9 store forms
    s0 = n_store;
    bus_start(); send_byte(8'h53, ack); send_byte(8'hE5, ack); bus_stop();
    check("R9 store one", n_store, s0 + 1);
    bus_start(); send_byte(8'h53, ack); send_byte(8'h88, ack); bus_stop();
    check("R9 store all", n_store, s0 + 2);
    bus_start(); send_byte(8'h53, ack); send_byte(8'hC1, ack);
    send_byte(8'h07, ack); bus_stop();
    check("R9 write reg with data", n_store, s0 + 3);
    bus_start(); send_byte(8'h53, ack); send_byte(8'hC1, ack); bus_stop();
    check("R9 write reg without data", n_store, s0 + 3);

    // R10 repeated start cancels pending store and partial byte
    bus_start(); send_byte(8'h53, ack); send_byte(8'hE5, ack);
    bus_start(); send_byte(8'h53, ack);
    check("R10 addr after restart", ack, 1);
    bus_stop();
    check("R10 store dropped", n_store, s0 + 3);

    c0 = n_cmd;
    bus_start(); send_byte(8'h53, ack);
    for (int i = 0; i < 4; i++) bit_io(1'b1, ack);
    bus_start(); send_byte(8'h53, ack);
    check("R10 addr after mid-byte restart", ack, 1);
    send_byte(8'hD2, ack);
    check("R10 one cmd only", n_cmd, c0 + 1);
    check("R10 cmd fields", last_cmd, 8'hD2);
    bus_stop();

    // R3 busy released again
    busy = 1'b1;
    bus_start(); send_byte(8'h53, ack); bus_stop();
    check("R3 refused while busy", ack, 0);
    busy = 1'b0;
    bus_start(); send_byte(8'h53, ack); bus_stop();
    check("R3 ack after busy", ack, 1);

    check("R11 oe stable in scl high", n_viol, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule